// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a single pulse-width modulated output from a 10-bit time base. The time base pairs an 8-bit period timer with a 2-bit sub-count, and the sub-count advances once every 1, 4 or 16 input clocks, as set by a prescaler select. A software-visible 8-bit period value sets where the timer wraps. A 10-bit duty value, loaded as an 8-bit upper part and a 2-bit lower part through separate write strobes, sets how long the output stays high in each period.

Duty writes land in a master buffer and may arrive at any time. The buffer is copied into an active duty register only when the timer wraps, so a period that is already running always finishes with the value it started with. The active register is visible as a read-only output. Dropping the mode enable forces the output low and restarts the prescaler and time base. The first period after enable starts from zero with the output low.

Top module: `pwm10_gen`

## Requirements
- R1: Out of reset, `pwm_out` is 0 and `duty_active` is 0.
- R2: `presc_sel` 2'b00 steps the sub-count every clock, 2'b01 every 4 clocks, and 2'b10 or 2'b11 every 16 clocks. The output period is (period + 1) × 4 × divide clocks, measured between consecutive rising edges of `pwm_out`.
- R3: The duty value is {upper[7:0], lower[1:0]}: upper part in bits 9:2, lower part in bits 1:0. The output is high for duty × divide clocks from the start of each period.
- R4: Duty writes may occur at any time. A written value reaches `duty_active`, and governs the output, only from the next period boundary onward. The period in progress is unaffected.
- R5: With an active duty of 0, `pwm_out` is never set at a period boundary and stays low.
- R6: With a duty of at least (period + 1) × 4, `pwm_out` stays high for the whole period.
- R7: With `mode_en` low, `pwm_out` is 0 from the next clock onward, and the prescaler and time base return to zero.
- R8: After `mode_en` rises, the output stays low for exactly one full period. It rises on the clock edge that ends that period, counting the first edge that samples `mode_en` high as edge 1.
- R9: The upper-part strobe changes only duty bits 9:2, and the lower-part strobe changes only bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | PWM mode enable; low clears output and time base |
| presc_sel | input | 2 | Prescaler select: 00 ÷1, 01 ÷4, 1x ÷16 |
| period | input | 8 | Timer wrap value |
| duty_hi_we | input | 1 | Write strobe for duty bits 9:2 |
| duty_hi | input | 8 | Duty bits 9:2 |
| duty_lo_we | input | 1 | Write strobe for duty bits 1:0 |
| duty_lo | input | 2 | Duty bits 1:0 |
| pwm_out | output | 1 | PWM output |
| duty_active | output | 10 | Read-only active duty value |

## Verification
`pwm_out` is registered, so it changes one clock after the edge that ends a period or reaches the duty count. A write strobe appears in `duty_active` one clock after the rollover edge that follows it. Disabling clears the output on the first edge that samples `mode_en` low. The bench drives every input at a falling edge and samples at falling edges. After an enable it waits exactly N falling edges for the first rise, where N is the computed period. It then compares every cycle of each following period window with the expected level: high while the offset is below the computed high time, low otherwise. A single shifted edge, a wrong period or a wrong high time therefore shows up as a mismatch in the cycle where it occurs.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int TMR_W  = 8;
    localparam int SUB_W  = 2;
    localparam int BASE_W = TMR_W + SUB_W;
    localparam int PRE_W  = 4;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV4   = 2'b01,
        PS_DIV16  = 2'b10,
        PS_DIV16B = 2'b11
    } presc_e;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [SUB_W-1:0] sub;
    } tbase_t;

    // last prescaler count before a sub-count step (divide - 1)
    function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
        case (presc_e'(sel))
            PS_DIV1: presc_last = PRE_W'(0);
            PS_DIV4: presc_last = PRE_W'(3);
            default: presc_last = PRE_W'(15);
        endcase
    endfunction

    function automatic logic [BASE_W-1:0] base_flat(input tbase_t b);
        base_flat = {b.tmr, b.sub};
    endfunction

endpackage

// File: rtl/pwm10_prescale.sv
module pwm10_prescale
    import pwm10_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       step
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] last;

    always_comb last = presc_last(sel);

    // >= keeps the divider safe when the select shrinks mid-count
    assign step = en && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_W'(1);
        end
    end

    AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst)
        (step && sel != 2'b00) |=> (sel == 2'b00 || !step))
        else $error("prescaler stepped on consecutive clocks"); // R2

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             step,
    input  logic [TMR_W-1:0] period,
    output logic             rollover,
    output tbase_t           base_next
);

    tbase_t            base;
    logic [BASE_W-1:0] incr;

    localparam logic [SUB_W-1:0] SUB_TOP = '1;

    assign rollover = step && (base.sub == SUB_TOP) && (base.tmr == period);

    always_comb begin
        incr = base_flat(base) + BASE_W'(1);
        if (!step) begin
            base_next = base;
        end else if (rollover) begin
            base_next = '0;
        end else begin
            base_next = tbase_t'(incr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            base <= '0;
        end else begin
            base <= base_next;
        end
    end

    AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (rst)
        rollover |=> (base_flat(base) == '0))
        else $error("time base not cleared after rollover"); // R2

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !step) |=> $stable(base))
        else $error("time base moved without a prescaler step"); // R2

endmodule

// File: rtl/pwm10_duty_buf.sv
module pwm10_duty_buf
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we,
    input  logic [TMR_W-1:0]  hi_d,
    input  logic              lo_we,
    input  logic [SUB_W-1:0]  lo_d,
    input  logic              latch,
    output logic [BASE_W-1:0] master,
    output logic [BASE_W-1:0] active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            master <= '0;
        end else begin
            if (hi_we) master[BASE_W-1:SUB_W] <= hi_d;
            if (lo_we) master[SUB_W-1:0]      <= lo_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (latch) begin
            active <= master;
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(active))
        else $error("active duty changed inside a period"); // R4

    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
        latch |=> (active == $past(master)))
        else $error("active duty not loaded from master at rollover"); // R4

    AST_HI_ONLY: assert property (@(posedge clk) disable iff (rst)
        (hi_we && !lo_we) |=> (master[SUB_W-1:0] == $past(master[SUB_W-1:0])))
        else $error("upper write disturbed lower duty bits"); // R9

endmodule

// File: rtl/pwm10_out_stage.sv
module pwm10_out_stage
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              step,
    input  logic              rollover,
    input  tbase_t            base_next,
    input  logic [BASE_W-1:0] duty_now,
    input  logic [BASE_W-1:0] duty_new,
    output logic              pwm_q
);

    logic hit;

    assign hit = step && (base_flat(base_next) == duty_now);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pwm_q <= 1'b0;
        end else if (rollover) begin
            pwm_q <= (duty_new != '0);
        end else if (hit) begin
            pwm_q <= 1'b0;
        end
    end

    AST_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_q)
        else $error("output high while disabled"); // R7

    AST_ZERO_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (rollover && duty_new == '0) |=> !pwm_q)
        else $error("output set with zero duty"); // R5

    AST_RISE_AT_ROLL: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_q) |-> $past(rollover))
        else $error("output rose away from a period boundary"); // R8

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_en,
    input  logic [1:0]        presc_sel,
    input  logic [TMR_W-1:0]  period,
    input  logic              duty_hi_we,
    input  logic [TMR_W-1:0]  duty_hi,
    input  logic              duty_lo_we,
    input  logic [SUB_W-1:0]  duty_lo,
    output logic              pwm_out,
    output logic [BASE_W-1:0] duty_active
);

    logic              step;
    logic              rollover;
    tbase_t            base_next;
    logic [BASE_W-1:0] duty_master;

    pwm10_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (mode_en),
        .sel  (presc_sel),
        .step (step)
    );

    pwm10_timebase u_tb (
        .clk       (clk),
        .rst       (rst),
        .en        (mode_en),
        .step      (step),
        .period    (period),
        .rollover  (rollover),
        .base_next (base_next)
    );

    pwm10_duty_buf u_duty (
        .clk    (clk),
        .rst    (rst),
        .hi_we  (duty_hi_we),
        .hi_d   (duty_hi),
        .lo_we  (duty_lo_we),
        .lo_d   (duty_lo),
        .latch  (rollover),
        .master (duty_master),
        .active (duty_active)
    );

    pwm10_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .en        (mode_en),
        .step      (step),
        .rollover  (rollover),
        .base_next (base_next),
        .duty_now  (duty_active),
        .duty_new  (duty_master),
        .pwm_q     (pwm_out)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!pwm_out && duty_active == '0))
        else $error("reset state wrong"); // R1

endmodule

// File: tb/sim_pwm10_gen.sv
`timescale 1ns/1ps
module sim_pwm10_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_en = 1'b0;
    logic [1:0] presc_sel = 2'b00;
    logic [7:0] period = 8'd0;
    logic       duty_hi_we = 1'b0;
    logic [7:0] duty_hi = 8'd0;
    logic       duty_lo_we = 1'b0;
    logic [1:0] duty_lo = 2'b00;
    logic       pwm_out;
    logic [9:0] duty_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm10_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .mode_en     (mode_en),
        .presc_sel   (presc_sel),
        .period      (period),
        .duty_hi_we  (duty_hi_we),
        .duty_hi     (duty_hi),
        .duty_lo_we  (duty_lo_we),
        .duty_lo     (duty_lo),
        .pwm_out     (pwm_out),
        .duty_active (duty_active)
    );

    function automatic int div_of(input logic [1:0] s);
        if (s == 2'b00) return 1;
        if (s == 2'b01) return 4;
        return 16;
    endfunction

    function automatic int per_of(input int pr, input logic [1:0] s);
        return (pr + 1) * 4 * div_of(s);
    endfunction

    function automatic int high_of(input int duty, input int pr, input logic [1:0] s);
        int h;
        h = duty * div_of(s);
        if (h > per_of(pr, s)) h = per_of(pr, s);
        return h;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_duty(input int d);
        logic [9:0] dv;
        dv = d[9:0];
        @(negedge clk);
        duty_hi = dv[9:2];
        duty_hi_we = 1'b1;
        @(negedge clk);
        duty_hi_we = 1'b0;
        duty_lo = dv[1:0];
        duty_lo_we = 1'b1;
        @(negedge clk);
        duty_lo_we = 1'b0;
    endtask

    // disable, program, then enable at the current falling edge
    task automatic start(input logic [1:0] ps, input int pr, input int duty);
        @(negedge clk);
        mode_en = 1'b0;
        presc_sel = ps;
        period = pr[7:0];
        set_duty(duty);
        mode_en = 1'b1;
    endtask

    // R8: low for n-1 samples, then the level at sample n
    task automatic first_period(input int n, input bit rise, input string req);
        int bad;
        bad = 0;
        for (int c = 1; c < n; c++) begin
            @(negedge clk);
            if (pwm_out) bad++;
        end
        @(negedge clk);
        chk(bad == 0 && pwm_out == rise, req, bad * 2 + int'(pwm_out), int'(rise));
    endtask

    // checks one period starting at offset 0; optional write at offset wr_at
    task automatic run_period(input int h, input int n, input string req,
                              input int wr_at, input bit wr_hi, input int wr_val);
        int bad;
        int hc;
        bad = 0;
        hc = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out != (i < h)) bad++;
            if (pwm_out) hc++;
            if (i == wr_at) begin
                if (wr_hi) begin
                    duty_hi = wr_val[7:0];
                    duty_hi_we = 1'b1;
                end else begin
                    duty_lo = wr_val[1:0];
                    duty_lo_we = 1'b1;
                end
            end else begin
                duty_hi_we = 1'b0;
                duty_lo_we = 1'b0;
            end
            @(negedge clk);
        end
        chk(bad == 0, req, hc, h);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run hung actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int h;
        int seed_dummy;
        seed_dummy = $urandom(32'd20417);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R1 output", int'(pwm_out), 0);
        chk(duty_active == 10'd0, "R1 active duty", int'(duty_active), 0);

        // R2 R3: prescale /1, period register 3, duty 6
        start(2'b00, 3, 6);
        n = per_of(3, 2'b00);
        first_period(n, 1'b1, "R8 first period div1");
        chk(duty_active == 10'd6, "R4 latched at first rollover", int'(duty_active), 6);
        run_period(high_of(6, 3, 2'b00), n, "R3 high time div1", -1, 1'b0, 0);

        // R4 R9: upper-part write mid-period, old duty holds this period
        run_period(6, n, "R4 current period unchanged", 3, 1'b1, 2);
        chk(duty_active == 10'd10, "R4 R9 upper write applied next period",
            int'(duty_active), 10);
        run_period(10, n, "R4 new duty high time", 5, 1'b0, 0);
        chk(duty_active == 10'd8, "R9 lower write only bits 1:0",
            int'(duty_active), 8);
        run_period(8, n, "R9 high time after lower write", -1, 1'b0, 0);

        // R2: prescale /4 and /16 (both 1x codes)
        start(2'b01, 2, 5);
        n = per_of(2, 2'b01);
        first_period(n, 1'b1, "R8 first period div4");
        run_period(high_of(5, 2, 2'b01), n, "R2 period div4", -1, 1'b0, 0);
        start(2'b11, 1, 3);
        n = per_of(1, 2'b11);
        first_period(n, 1'b1, "R8 first period div16 code 11");
        run_period(high_of(3, 1, 2'b11), n, "R2 period div16 code 11", -1, 1'b0, 0);

        // R5: zero duty
        start(2'b00, 4, 0);
        n = per_of(4, 2'b00);
        first_period(n, 1'b0, "R5 zero duty first boundary");
        run_period(0, n, "R5 zero duty stays low", -1, 1'b0, 0);

        // R6: duty beyond the period, and exactly equal to it
        start(2'b01, 5, 1023);
        n = per_of(5, 2'b01);
        first_period(n, 1'b1, "R6 large duty rise");
        run_period(n, n, "R6 large duty full high", -1, 1'b0, 0);
        start(2'b00, 5, 24);
        n = per_of(5, 2'b00);
        first_period(n, 1'b1, "R6 duty equal period rise");
        run_period(n, n, "R6 duty equal period full high", -1, 1'b0, 0);

        // R7: disable while high, then restart
        start(2'b00, 3, 10);
        n = per_of(3, 2'b00);
        first_period(n, 1'b1, "R8 before disable");
        repeat (4) @(negedge clk);
        mode_en = 1'b0;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R7 disable forces low", int'(pwm_out), 0);
        mode_en = 1'b1;
        first_period(n, 1'b1, "R7 R8 restart from zero");
        run_period(10, n, "R7 period after restart", -1, 1'b0, 0);

        // random configurations
        for (int k = 0; k < 20; k++) begin
            logic [1:0] ps;
            int pr;
            int duty;
            int pick;
            ps = 2'($urandom % 4);
            pr = int'($urandom % 12);
            pick = int'($urandom % 6);
            if (pick == 0) duty = 0;
            else if (pick == 1) duty = (pr + 1) * 4 + int'($urandom % 64);
            else duty = int'($urandom % ((pr + 1) * 4 + 2));
            if (duty > 1023) duty = 1023;
            n = per_of(pr, ps);
            h = high_of(duty, pr, ps);
            start(ps, pr, duty);
            first_period(n, duty != 0, "R8 random first period");
            chk(duty_active == 10'(duty), "R4 random active duty",
                int'(duty_active), duty);
            run_period(h, n, "R2 R3 random period 1", -1, 1'b0, 0);
            run_period(h, n, "R2 R3 random period 2", -1, 1'b0, 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule